// File: doc/BRIEF.md
# Whole-Page Hamming ECC Engine

This block sits beside the data path between a host and a NAND flash device. It snoops every data word that crosses that path and builds one Hamming code over the whole data area of a page. The code is kept as two 16-bit words: a parity word and a complementary parity word. When a page is written, software reads both words once the last data word has passed and stores them as four spare-area bytes.

When a page is read, the host streams the data area and then, with nothing in between, the four stored ECC bytes. The engine compares the stored code with the one it computed. It reports one of four outcomes: the page is clean, one data bit is wrong (with the word index and the bit offset of that bit), one bit of the stored code is wrong, or the error cannot be corrected. A freshly erased page, with every data and code byte equal to 0xFF, reads as uncorrectable with every location bit set, so software can recognise it. A mode input picks one of four page sizes. A clear pulse, or a mode write, starts a new page.

Top module: `ecc_page_engine`

## Requirements
- R1: A `clear_i` pulse or a `mode_we_i` write makes, from the next cycle, `parity_o` and `nparity_o` read 0 and `done_o`, `err_rec_o`, `err_multi_o` and `err_ecc_o` read 0.
- R2: The mode value 0, 1, 2 or 3 (latched on `mode_we_i`) selects 512, 1024, 2048 or 4096 data bytes. That is (4096 << mode)/W data words, followed by 32/W code words.
- R3: For each data bit equal to 1, let its address be the 16-bit value {word index[11:0], bit offset[3:0]}. `parity_o` is the XOR of all these addresses, and `nparity_o` is the XOR of their bitwise inverses.
- R4: The code words follow the last data word in byte order parity[7:0], parity[15:8], nparity[7:0], nparity[15:8]. With W=16, code word 0 is the parity word and code word 1 is the complementary parity word.
- R5: If the stored code matches the computed one, `done_o` is 1, `parity_o` reads 0 and all error flags are 0.
- R6: A single flipped data bit sets `err_rec_o` only. `parity_o` then reads the word index in bits [15:4] and the bit offset in bits [3:0].
- R7: A single flipped bit in the stored code sets `err_rec_o` and `err_ecc_o`, and leaves `err_multi_o` at 0.
- R8: Two flipped data bits set `err_rec_o` and `err_multi_o`, and leave `err_ecc_o` at 0.
- R9: A page whose data and code bytes are all 0xFF gives `err_multi_o`=1 and `parity_o`=16'hFFFF.
- R10: Once `done_o` is 1, further valid words are ignored. All outputs hold until the next clear or mode write.
- R11: Until the code words have all arrived, `parity_o` and `nparity_o` show the computed code and `done_o` is 0. `done_o` rises in the cycle after the edge that accepts the last code word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clear_i | input | 1 | Pulse that starts a new page |
| mode_we_i | input | 1 | Loads `mode_i` and starts a new page |
| mode_i | input | 2 | Page size code (R2) |
| valid_i | input | 1 | A data word is on the bus this cycle |
| data_i | input | W | Snooped bus word |
| parity_o | output | 16 | Computed parity word, or the syndrome once done |
| nparity_o | output | 16 | Computed complementary parity word |
| done_o | output | 1 | Data and code words all received |
| err_rec_o | output | 1 | Any mismatch |
| err_multi_o | output | 1 | Uncorrectable pattern |
| err_ecc_o | output | 1 | Single bit error inside the stored code |

## Verification
Each word is registered at the clock edge that accepts it, so the parity words and the flags are due one cycle after the edge that takes the last data word or the last code word. The bench drives each word at a falling edge and samples results at the next falling edge, half a cycle after the register update. To time `done_o`, the bench checks it low one word before the end and high one word after the end.

// File: rtl/ecc_pkg.sv
package ecc_pkg;
    localparam int CNT_W = 14;

    typedef struct packed {
        logic [1:0]       mode;
        logic [CNT_W-1:0] cnt;
        logic [15:0]      p;
        logic [15:0]      n;
        logic [31:0]      stored;
    } eng_state_t;

    typedef struct packed {
        logic rec;
        logic multi;
        logic ecc;
    } eng_flags_t;
endpackage

// File: rtl/ecc_word_contrib.sv
module ecc_word_contrib #(
    parameter int W = 8
) (
    input  logic [W-1:0] word_i,
    input  logic [11:0]  idx_i,
    output logic [15:0]  cp_o,
    output logic [15:0]  cn_o
);
    always_comb begin
        cp_o = '0;
        cn_o = '0;
        for (int b = 0; b < W; b++) begin
            if (word_i[b]) begin
                cp_o = cp_o ^ {idx_i, 4'(b)};
                cn_o = cn_o ^ ~{idx_i, 4'(b)};
            end
        end
    end
endmodule

// File: rtl/ecc_syndrome_dec.sv
module ecc_syndrome_dec
    import ecc_pkg::*;
(
    input  logic        valid_i,
    input  logic [15:0] calc_p_i,
    input  logic [15:0] calc_n_i,
    input  logic [31:0] stored_i,
    output logic [15:0] syn_o,
    output eng_flags_t  flags_o
);
    logic [15:0] sp;
    logic [15:0] sn;

    always_comb begin
        sp      = calc_p_i ^ stored_i[15:0];
        sn      = calc_n_i ^ stored_i[31:16];
        syn_o   = sp;
        flags_o = '0;
        if (valid_i) begin
            if (sp == 16'h0 && sn == 16'h0) begin
                flags_o = '0;
            end else if (sp == ~sn) begin
                flags_o.rec = 1'b1;
            end else if ($countones({sp, sn}) == 1) begin
                flags_o.rec = 1'b1;
                flags_o.ecc = 1'b1;
            end else begin
                flags_o.rec   = 1'b1;
                flags_o.multi = 1'b1;
            end
        end
    end
endmodule

// File: rtl/ecc_page_engine.sv
module ecc_page_engine
    import ecc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear_i,
    input  logic         mode_we_i,
    input  logic [1:0]   mode_i,
    input  logic         valid_i,
    input  logic [W-1:0] data_i,
    output logic [15:0]  parity_o,
    output logic [15:0]  nparity_o,
    output logic         done_o,
    output logic         err_rec_o,
    output logic         err_multi_o,
    output logic         err_ecc_o
);
    localparam int ECC_WORDS = 32 / W;
    localparam int BASE_WORDS = 4096 / W;

    eng_state_t       st_q, st_d;
    logic [CNT_W-1:0] data_words;
    logic [CNT_W-1:0] total_words;
    logic [CNT_W-1:0] ecc_idx;
    logic [15:0]      cp, cn, syn;
    logic             in_data, in_ecc, done;
    eng_flags_t       flags;

    ecc_word_contrib #(.W(W)) u_contrib (
        .word_i (data_i),
        .idx_i  (st_q.cnt[11:0]),
        .cp_o   (cp),
        .cn_o   (cn)
    );

    ecc_syndrome_dec u_dec (
        .valid_i  (done),
        .calc_p_i (st_q.p),
        .calc_n_i (st_q.n),
        .stored_i (st_q.stored),
        .syn_o    (syn),
        .flags_o  (flags)
    );

    always_comb begin
        data_words  = CNT_W'(BASE_WORDS) << st_q.mode;
        total_words = data_words + CNT_W'(ECC_WORDS);
        ecc_idx     = st_q.cnt - data_words;
        in_data     = st_q.cnt < data_words;
        in_ecc      = !in_data && (st_q.cnt < total_words);
        done        = st_q.cnt == total_words;

        st_d = st_q;
        if (mode_we_i || clear_i) begin
            if (mode_we_i) st_d.mode = mode_i;
            st_d.cnt    = '0;
            st_d.p      = '0;
            st_d.n      = '0;
            st_d.stored = '0;
        end else if (valid_i && in_data) begin
            st_d.p   = st_q.p ^ cp;
            st_d.n   = st_q.n ^ cn;
            st_d.cnt = st_q.cnt + 1'b1;
        end else if (valid_i && in_ecc) begin
            for (int k = 0; k < ECC_WORDS; k++) begin
                if (ecc_idx == CNT_W'(k)) st_d.stored[k*W +: W] = data_i;
            end
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign parity_o    = done ? syn : st_q.p;
    assign nparity_o   = st_q.n;
    assign done_o      = done;
    assign err_rec_o   = flags.rec;
    assign err_multi_o = flags.multi;
    assign err_ecc_o   = flags.ecc;
endmodule

// File: rtl/ecc_page_engine_chk.sv
module ecc_page_engine_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        clear_i,
    input logic        mode_we_i,
    input logic        valid_i,
    input logic [15:0] parity_o,
    input logic [15:0] nparity_o,
    input logic        done_o,
    input logic        err_rec_o,
    input logic        err_multi_o,
    input logic        err_ecc_o
);
    assert_restart_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_i || mode_we_i) |=> (!done_o && parity_o == 16'h0 && nparity_o == 16'h0 && !err_rec_o));

    assert_flags_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> !(err_rec_o || err_multi_o || err_ecc_o));

    assert_flag_class_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (err_multi_o || err_ecc_o) |-> (err_rec_o && !(err_multi_o && err_ecc_o)));

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && $past(done_o)) |-> ($stable(parity_o) && $stable(nparity_o) &&
                                       $stable(err_rec_o) && $stable(err_multi_o) && $stable(err_ecc_o)));

    assert_done_rise_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(valid_i));
endmodule

bind ecc_page_engine ecc_page_engine_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear_i     (clear_i),
    .mode_we_i   (mode_we_i),
    .valid_i     (valid_i),
    .parity_o    (parity_o),
    .nparity_o   (nparity_o),
    .done_o      (done_o),
    .err_rec_o   (err_rec_o),
    .err_multi_o (err_multi_o),
    .err_ecc_o   (err_ecc_o)
);

// File: tb/sim_ecc_page_engine.sv
`timescale 1ns/1ps
module sim_ecc_page_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clear_i = 1'b0;
    logic        mode_we_i = 1'b0;
    logic [1:0]  mode_i = 2'd0;
    logic        valid_i = 1'b0;
    logic [7:0]  data_i = 8'h0;
    logic [15:0] parity_o, nparity_o;
    logic        done_o, err_rec_o, err_multi_o, err_ecc_o;

    int total = 0;
    int bad = 0;
    logic [7:0] page [0:4095];

    always #4 clk = ~clk;

    ecc_page_engine #(.W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .mode_we_i(mode_we_i),
        .mode_i(mode_i), .valid_i(valid_i), .data_i(data_i),
        .parity_o(parity_o), .nparity_o(nparity_o), .done_o(done_o),
        .err_rec_o(err_rec_o), .err_multi_o(err_multi_o), .err_ecc_o(err_ecc_o)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic check_flags(string req, logic [3:0] exp);
        check(req, {28'h0, done_o, err_rec_o, err_multi_o, err_ecc_o}, {28'h0, exp});
    endtask

    task automatic fill(int nbytes, int seed);
        for (int i = 0; i < nbytes; i++) page[i] = 8'((i * 37 + seed) ^ (i >> 3));
    endtask

    function automatic logic [31:0] calc_code(int nbytes);
        logic [15:0] p = 16'h0;
        logic [15:0] n = 16'h0;
        for (int i = 0; i < nbytes; i++)
            for (int b = 0; b < 8; b++)
                if (page[i][b]) begin
                    p = p ^ {i[11:0], 4'(b)};
                    n = n ^ ~{i[11:0], 4'(b)};
                end
        return {n, p};
    endfunction

    task automatic put(logic [7:0] d);
        @(negedge clk);
        valid_i = 1'b1;
        data_i  = d;
    endtask

    task automatic idle;
        @(negedge clk);
        valid_i = 1'b0;
    endtask

    task automatic restart;
        @(negedge clk); clear_i = 1'b1;
        @(negedge clk); clear_i = 1'b0;
    endtask

    task automatic send_data(int nbytes);
        for (int i = 0; i < nbytes; i++) put(page[i]);
    endtask

    task automatic send_code(logic [31:0] c);
        put(c[7:0]); put(c[15:8]); put(c[23:16]); put(c[31:24]);
        idle;
    endtask

    task automatic t_reset;
        @(negedge clk);
        check("R1 reset parity", {16'h0, parity_o}, 32'h0);
        check("R1 reset nparity", {16'h0, nparity_o}, 32'h0);
        check_flags("R1 reset flags", 4'b0000);
    endtask

    task automatic t_clean;
        logic [31:0] c;
        restart;
        fill(512, 11);
        c = calc_code(512);
        send_data(512);
        idle;
        check("R3 parity after write", {16'h0, parity_o}, {16'h0, c[15:0]});
        check("R3 nparity after write", {16'h0, nparity_o}, {16'h0, c[31:16]});
        check_flags("R11 not done before code", 4'b0000);
        send_code(c);
        check_flags("R5 R4 clean page", 4'b1000);
        check("R5 syndrome zero", {16'h0, parity_o}, 32'h0);
    endtask

    task automatic t_single;
        logic [31:0] c;
        restart;
        fill(512, 5);
        c = calc_code(512);
        page[300][5] = ~page[300][5];
        send_data(512);
        send_code(c);
        check_flags("R6 single data error", 4'b1100);
        check("R6 location", {16'h0, parity_o}, {16'h0, 12'd300, 4'd5});
        page[300][5] = ~page[300][5];
        // extra words after done must be ignored
        put(8'hA5); put(8'h3C); put(8'h00);
        idle;
        check_flags("R10 flags hold", 4'b1100);
        check("R10 location hold", {16'h0, parity_o}, {16'h0, 12'd300, 4'd5});
    endtask

    task automatic t_last_bit;
        logic [31:0] c;
        restart;
        fill(512, 77);
        c = calc_code(512);
        page[511][0] = ~page[511][0];
        send_data(512);
        send_code(c);
        check_flags("R6 last word error", 4'b1100);
        check("R6 last word location", {16'h0, parity_o}, {16'h0, 12'd511, 4'd0});
    endtask

    task automatic t_code_flip;
        logic [31:0] c;
        restart;
        fill(512, 23);
        c = calc_code(512);
        send_data(512);
        send_code(c ^ 32'h0004_0000);
        check_flags("R7 code bit error", 4'b1101);
    endtask

    task automatic t_double;
        logic [31:0] c;
        restart;
        fill(512, 41);
        c = calc_code(512);
        page[10][1] = ~page[10][1];
        page[200][6] = ~page[200][6];
        send_data(512);
        send_code(c);
        check_flags("R8 double data error", 4'b1110);
    endtask

    task automatic t_erased;
        restart;
        for (int i = 0; i < 512; i++) page[i] = 8'hFF;
        send_data(512);
        send_code(32'hFFFF_FFFF);
        check_flags("R9 erased page", 4'b1110);
        check("R9 erased location", {16'h0, parity_o}, 32'h0000_FFFF);
    endtask

    task automatic t_mode1;
        logic [31:0] c;
        @(negedge clk); mode_i = 2'd1; mode_we_i = 1'b1;
        @(negedge clk); mode_we_i = 1'b0;
        check_flags("R1 mode write clears", 4'b0000);
        check("R1 mode write parity", {16'h0, parity_o}, 32'h0);
        fill(1024, 99);
        c = calc_code(1024);
        send_data(1024);
        put(c[7:0]); put(c[15:8]); put(c[23:16]);
        idle;
        check_flags("R2 not done one word early", 4'b0000);
        put(c[31:24]);
        idle;
        check_flags("R2 R11 1024-byte page clean", 4'b1000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset;
        t_clean;
        t_single;
        t_last_bit;
        t_code_flip;
        t_double;
        t_erased;
        t_mode1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule